// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four modem handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) and builds an 8-bit modem status byte for a serial port's register file. The upper nibble reports the present level of each line. The lower nibble holds sticky change flags that the host collects and clears by reading the status byte. Whenever a flag is pending and the host has enabled modem-status interrupts, the block raises a request toward the port's interrupt logic.

The pin inputs pass through a two-stage synchroniser (depth set by a parameter) before any level or edge is taken from them. A loopback mode lets diagnostic software test the path without a cable. In that mode the block takes its four inputs from the port's own modem-control outputs, already in the core clock domain, and ignores the pins. Bit 2 behaves differently from the other flags: it latches only when a ring ends, not when it starts.

Top module: `modem_status_monitor`

## Requirements
- R1: After reset, `status` reads 8'h00 and `msi_req` is low.
- R2: `status` bits 4, 5, 6 and 7 give the levels of CTS, DSR, RI and DCD. A pin change made before rising edge 1 is not visible after edge 2 and is visible after edge 3, with the default of two synchroniser stages.
- R3: Bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) latch to 1 on every change of their line, rising or falling.
- R4: Bit 2 latches to 1 only when RI goes from 1 to 0. A rise of RI leaves bit 2 clear.
- R5: Flags stay set until a read. A cycle with `status_rd` high still presents the flags, and all four flags are cleared at the closing clock edge of that cycle.
- R6: A change that lands in the same edge as a read clears the other flags but stays latched.
- R7: `msi_req` is high exactly when `msi_en` is high and at least one of bits 3..0 is set.
- R8: With `loop_en` high, CTS comes from `lb_rts`, DSR from `lb_dtr`, RI from `lb_out1` and DCD from `lb_out2`. These inputs skip the synchroniser and are reflected one rising edge after they change.
- R9: With `loop_en` high, the four pins have no effect on `status`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_pin | input | 1 | Clear-to-send line, asynchronous |
| dsr_pin | input | 1 | Data-set-ready line, asynchronous |
| ri_pin | input | 1 | Ring indicator line, asynchronous |
| dcd_pin | input | 1 | Carrier detect line, asynchronous |
| loop_en | input | 1 | Loopback select |
| lb_dtr | input | 1 | Terminal-ready control output, looped to DSR |
| lb_rts | input | 1 | Request-to-send control output, looped to CTS |
| lb_out1 | input | 1 | User output 1, looped to RI |
| lb_out2 | input | 1 | User output 2, looped to DCD |
| status_rd | input | 1 | Host read strobe for the status byte |
| msi_en | input | 1 | Modem-status interrupt enable |
| status | output | 8 | Levels in [7:4], change flags in [3:0] |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
Several properties are checked on every cycle. A level change on CTS, DSR or DCD is always accompanied by its flag. Bit 2 rises only together with a falling RI level. A flag holds until a read. A read with no incoming change empties the flags. In loopback the levels follow the looped controls, and the request never appears without both the enable and a pending flag. Other behaviours depend on exact cycle placement and are shown only by the bench's scenarios: the three-edge pin latency, a change colliding with a read, the pins being ignored in loopback, and leaving loopback with a rising RI that sets no flag.

// File: rtl/modem_status_monitor.sv
module modem_status_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_pin,
  input  logic       dsr_pin,
  input  logic       ri_pin,
  input  logic       dcd_pin,
  input  logic       loop_en,
  input  logic       lb_dtr,
  input  logic       lb_rts,
  input  logic       lb_out1,
  input  logic       lb_out2,
  input  logic       status_rd,
  input  logic       msi_en,
  output logic [7:0] status,
  output logic       msi_req
);
  localparam int NL = 4;
  localparam int RI = 2;

  logic [NL-1:0] pin_vec, loop_vec, src, lvl_q, flags_q, toggled, hit;
  logic [NL-1:0] sync_q [SYNC_STAGES];

  assign pin_vec  = {dcd_pin, ri_pin, dsr_pin, cts_pin};
  assign loop_vec = {lb_out2, lb_out1, lb_dtr, lb_rts};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pin_vec;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  assign src     = loop_en ? loop_vec : sync_q[SYNC_STAGES-1];
  assign toggled = src ^ lvl_q;

  generate
    for (genvar g = 0; g < NL; g++) begin : g_hit
      if (g == RI) begin : g_trail
        assign hit[g] = lvl_q[g] & ~src[g];
      end else begin : g_any
        assign hit[g] = toggled[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q   <= '0;
      flags_q <= '0;
    end else begin
      lvl_q   <= src;
      flags_q <= (status_rd ? '0 : flags_q) | hit;
    end

  assign status  = {lvl_q, flags_q};
  assign msi_req = msi_en & (|flags_q);
endmodule

module modem_status_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       status_rd,
  input logic       msi_en,
  input logic       msi_req,
  input logic [7:0] status,
  input logic       loop_en,
  input logic       lb_rts,
  input logic       lb_dtr,
  input logic [3:0] src,
  input logic [3:0] lvl
);
  p_cts_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status[4]) |-> status[0]);
  p_dsr_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status[5]) |-> status[1]);
  p_dcd_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status[7]) |-> status[3]);
  p_ri_trail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $fell(status[6]));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_rd && status[0]) |=> status[0]);
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && src == lvl) |=> status[3:0] == 4'h0);
  p_req_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> (msi_en && status[3:0] != 4'h0));
  p_loop_cts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> status[4] == $past(lb_rts));
  p_loop_dsr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> status[5] == $past(lb_dtr));
endmodule

bind modem_status_monitor modem_status_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status_rd(status_rd), .msi_en(msi_en),
  .msi_req(msi_req), .status(status), .loop_en(loop_en), .lb_rts(lb_rts),
  .lb_dtr(lb_dtr), .src(src), .lvl(lvl_q)
);

// File: tb/modem_status_monitor_test.sv
module modem_status_monitor_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic cts_pin = 0, dsr_pin = 0, ri_pin = 0, dcd_pin = 0;
  logic loop_en = 0, lb_dtr = 0, lb_rts = 0, lb_out1 = 0, lb_out2 = 0;
  logic status_rd = 0, msi_en = 0;
  logic [7:0] status;
  logic msi_req;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_monitor uut (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input logic [7:0] exp_before, input logic [7:0] exp_after);
    status_rd = 1; #1;
    check(req, status, exp_before);
    cyc(1); status_rd = 0; #1;
    check(req, status, exp_after);
  endtask

  task automatic t_reset;
    check("R1 status", status, 8'h00);
    check("R1 msi_req", {7'd0, msi_req}, 8'h00);
  endtask

  task automatic t_cts;
    cts_pin = 1; cyc(2);
    check("R2 latency", status, 8'h00);
    cyc(1);
    check("R2 R3 cts rise", status, 8'h11);
    check("R7 disabled", {7'd0, msi_req}, 8'h00);
    msi_en = 1; #1;
    check("R7 enabled", {7'd0, msi_req}, 8'h01);
    do_read("R5 read clear", 8'h11, 8'h10);
    check("R7 after read", {7'd0, msi_req}, 8'h00);
    cts_pin = 0; cyc(3);
    check("R3 cts fall", status, 8'h01);
    do_read("R5", 8'h01, 8'h00);
  endtask

  task automatic t_dsr_dcd;
    dsr_pin = 1; cyc(3);
    check("R3 dsr rise", status, 8'h22);
    do_read("R5", 8'h22, 8'h20);
    dsr_pin = 0; cyc(3);
    check("R3 dsr fall", status, 8'h02);
    do_read("R5", 8'h02, 8'h00);
    dcd_pin = 1; cyc(3);
    check("R3 dcd rise", status, 8'h88);
    do_read("R5", 8'h88, 8'h80);
  endtask

  task automatic t_ring;
    ri_pin = 1; cyc(3);
    check("R4 ri rise no flag", status, 8'hC0);
    ri_pin = 0; cyc(3);
    check("R4 ri trailing edge", status, 8'h84);
    do_read("R5", 8'h84, 8'h80);
  endtask

  task automatic t_collide;
    dcd_pin = 0; cyc(2);
    status_rd = 1; cyc(1); status_rd = 0; #1;
    check("R6 change during read kept", status, 8'h08);
    do_read("R5", 8'h08, 8'h00);
  endtask

  task automatic t_loop;
    loop_en = 1; cyc(1);
    check("R8 loop idle", status, 8'h00);
    lb_rts = 1; cyc(1);
    check("R8 rts to cts", status, 8'h11);
    do_read("R8", 8'h11, 8'h10);
    lb_dtr = 1; cyc(1);
    check("R8 dtr to dsr", status, 8'h32);
    do_read("R8", 8'h32, 8'h30);
    lb_out1 = 1; cyc(1);
    check("R8 out1 to ri", status, 8'h70);
    lb_out1 = 0; cyc(1);
    check("R8 R4 looped trailing", status, 8'h34);
    do_read("R8", 8'h34, 8'h30);
    lb_out2 = 1; cyc(1);
    check("R8 out2 to dcd", status, 8'hB8);
    do_read("R8", 8'hB8, 8'hB0);
    cts_pin = 1; dsr_pin = 1; ri_pin = 1; dcd_pin = 0; cyc(4);
    check("R9 pins ignored", status, 8'hB0);
    dcd_pin = 1; cyc(4);
    check("R9 pins ignored", status, 8'hB0);
    loop_en = 0; cyc(1);
    check("R8 R4 leave loop ri rise", status, 8'hF0);
    check("R7 no flag", {7'd0, msi_req}, 8'h00);
  endtask

  task automatic t_gate;
    msi_en = 0; cts_pin = 0; cyc(3);
    check("R3 cts fall", status, 8'hE1);
    check("R7 gated", {7'd0, msi_req}, 8'h00);
    msi_en = 1; #1;
    check("R7 ungated", {7'd0, msi_req}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset;
    t_cts;
    t_dsr_dcd;
    t_ring;
    t_collide;
    t_loop;
    t_gate;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule